// File: doc/BRIEF.md
# Prescaled Auto-Reload Interval Timer

This block raises periodic interrupts from two counters in series. An 8-bit prescaler divides the clock. Each time it expires, a 16-bit down-counter takes one step. When a step finds the counter at zero, the counter reloads from a separate period register and the block emits a one-clock interrupt pulse. The sequence then repeats with no further writes.

Software writes a scale value, a period value, a direct count value and an enable bit through one write port. A select field picks the target register. The current count is always visible on an output so that software can read it back. Clearing the enable bit freezes both counters. Setting it again resumes counting from the frozen values.

Top module: `interval_timer`

## Requirements
- R1: After reset the count output reads 0, the interrupt output is low and the timer is disabled, with period and scale both 0.
- R2: A write with `wr_en_i` high takes effect at the clock edge. The select codes are: 0 = control (bit 0 of data is the enable bit), 1 = scale (low 8 data bits), 2 = period, 3 = count. The count output always shows the present count.
- R3: While enabled, the prescaler expires once every scale+1 clock cycles. A write to the scale register also loads the prescaler, so after a scale write the first expiry comes scale+1 cycles after counting starts.
- R4: Each prescaler expiry that finds the count nonzero lowers the count by exactly one.
- R5: A prescaler expiry that finds the count at zero reloads the count from the period register. Successive interrupts are therefore (scale+1)*(period+1) cycles apart.
- R6: The interrupt output is a pulse one clock wide. It is high in the cycle in which the count output first shows the reloaded period value.
- R7: A count write sets the current count and leaves the period register unchanged. In a cycle where a count write and an expiry coincide, the write wins.
- R8: While disabled, the prescaler and the count hold their values and no interrupt occurs. After re-enabling, counting continues from the held values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Register select: 0 control, 1 scale, 2 period, 3 count |
| wr_data_i | input | 16 | Write data |
| count_o | output | 16 | Present count value |
| irq_o | output | 1 | One-cycle interrupt pulse on reload |

## Verification
The assertions assume that reset is applied at the start and that the write strobe and select lines are settled before each clock edge. They also assume that a count write may arrive in any cycle, so each counter property excludes cycles in which a count write occurs. The stimulus changes inputs only at falling edges and issues one write at a time. In the period sweep it writes the count only while the timer is disabled, so every interval it measures comes from free-running reloads alone.

// File: rtl/timer_pkg.sv
package timer_pkg;
  typedef enum logic [1:0] {
    SEL_CTRL   = 2'd0,
    SEL_SCALE  = 2'd1,
    SEL_PERIOD = 2'd2,
    SEL_COUNT  = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/timer_prescaler.sv
module timer_prescaler #(
  parameter int SCL_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             load_i,
  input  logic [SCL_W-1:0] load_val_i,
  input  logic [SCL_W-1:0] scale_i,
  output logic             tick_o
);
  localparam logic [SCL_W-1:0] ONE = SCL_W'(1);

  logic [SCL_W-1:0] pre_q, pre_d;
  logic             pre_en;

  always_comb begin
    tick_o = en_i && (pre_q == '0);
    pre_en = load_i || en_i;
    pre_d  = pre_q;
    if (load_i)      pre_d = load_val_i;
    else if (tick_o) pre_d = scale_i;
    else             pre_d = pre_q - ONE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pre_q <= '0;
    else if (pre_en) pre_q <= pre_d;
  end

  // R3: the prescaler steps down by one on each enabled cycle without a load
  assert_pre_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !load_i && pre_q != '0) |=> pre_q == $past(pre_q) - ONE);

  // R8: the prescaler holds its value while disabled and not loaded
  assert_pre_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !load_i) |=> $stable(pre_q));
endmodule

// File: rtl/timer_counter.sv
module timer_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             wr_cnt_i,
  input  logic             wr_per_i,
  input  logic [CNT_W-1:0] wr_data_i,
  output logic [CNT_W-1:0] count_o,
  output logic             irq_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d, per_q;
  logic             irq_q, irq_d, cnt_en, reload;

  always_comb begin
    reload = tick_i && (cnt_q == '0) && !wr_cnt_i;
    cnt_en = wr_cnt_i || tick_i;
    cnt_d  = cnt_q;
    if (wr_cnt_i)    cnt_d = wr_data_i;
    else if (reload) cnt_d = per_q;
    else             cnt_d = cnt_q - ONE;
    irq_d  = reload;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       per_q <= '0;
    else if (wr_per_i) per_q <= wr_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= irq_d;
  end

  assign count_o = cnt_q;
  assign irq_o   = irq_q;

  // R4: a step that finds a nonzero count lowers it by one
  assert_decrement_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !wr_cnt_i && cnt_q != '0) |=> cnt_q == $past(cnt_q) - ONE);

  // R5/R6: an interrupt cycle shows the period value as it stood before the edge
  assert_reload_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_q |-> cnt_q == $past(per_q));

  // R7: a count write always lands, whatever the step logic wants
  assert_count_write_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_cnt_i |=> (cnt_q == $past(wr_data_i) && !irq_q));

  // R8: without steps or writes, the count holds
  assert_count_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !wr_cnt_i) |=> ($stable(cnt_q) && !irq_q));
endmodule

// File: rtl/interval_timer.sv
module interval_timer #(
  parameter int CNT_W = 16,
  parameter int SCL_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [1:0]       wr_sel_i,
  input  logic [CNT_W-1:0] wr_data_i,
  output logic [CNT_W-1:0] count_o,
  output logic             irq_o
);
  import timer_pkg::*;

  reg_sel_e         sel;
  logic             en_q, en_d, wr_ctrl, wr_scale, wr_per, wr_cnt, tick;
  logic [SCL_W-1:0] scale_q, scale_d;

  always_comb begin
    sel      = reg_sel_e'(wr_sel_i);
    wr_ctrl  = wr_en_i && (sel == SEL_CTRL);
    wr_scale = wr_en_i && (sel == SEL_SCALE);
    wr_per   = wr_en_i && (sel == SEL_PERIOD);
    wr_cnt   = wr_en_i && (sel == SEL_COUNT);
    en_d     = wr_data_i[0];
    scale_d  = wr_data_i[SCL_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      en_q <= 1'b0;
    else if (wr_ctrl) en_q <= en_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       scale_q <= '0;
    else if (wr_scale) scale_q <= scale_d;
  end

  timer_prescaler #(.SCL_W(SCL_W)) u_pre (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (en_q),
    .load_i     (wr_scale),
    .load_val_i (scale_d),
    .scale_i    (scale_q),
    .tick_o     (tick)
  );

  timer_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick),
    .wr_cnt_i  (wr_cnt),
    .wr_per_i  (wr_per),
    .wr_data_i (wr_data_i),
    .count_o   (count_o),
    .irq_o     (irq_o)
  );

  // R8: an interrupt only follows a cycle in which the timer was enabled
  assert_irq_enabled_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> $past(en_q));

  // R6: a pulse is never followed by another unless steps come every cycle
  assert_irq_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && scale_q != '0 && !wr_en_i) |=> !irq_o);
endmodule

// File: tb/interval_timer_tb.sv
module interval_timer_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [1:0]  wr_sel_i = 2'd0;
  logic [15:0] wr_data_i = 16'd0;
  logic [15:0] count_o;
  logic        irq_o;

  int checks = 0;
  int failures = 0;

  interval_timer u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i),
    .wr_data_i(wr_data_i), .count_o(count_o), .irq_o(irq_o)
  );

  always #5 clk_i = ~clk_i;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [15:0] data);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_sel_i = sel; wr_data_i = data;
    @(posedge clk_i);
    #1 wr_en_i = 1'b0;
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(posedge clk_i);
    #2;
  endtask

  task automatic wait_irq(output int n);
    n = 0;
    do begin
      @(posedge clk_i); #2; n++;
    end while (!irq_o && n < 300);
  endtask

  initial begin
    #3_000_000;
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int gap;
    step(3);
    rst_ni = 1'b1;
    step(1);
    // R1: reset state
    check("R1 count", count_o, 0);
    check("R1 irq", irq_o, 0);
    // R8 / R1: disabled timer stays silent
    begin
      int seen = 0;
      for (int i = 0; i < 20; i++) begin step(1); if (irq_o) seen++; end
      check("R8 no irq while disabled", seen, 0);
      check("R1 count held", count_o, 0);
    end

    // R2/R4/R8: run, freeze, resume with scale 0
    wr(2'd1, 16'd0);
    wr(2'd2, 16'd100);
    wr(2'd3, 16'd50);
    check("R2 count write visible", count_o, 50);
    wr(2'd0, 16'd1);
    step(10);
    check("R4 ten decrements", count_o, 40);
    wr(2'd0, 16'd0);
    check("R8 last step at disable edge", count_o, 39);
    step(5);
    check("R8 frozen", count_o, 39);
    wr(2'd0, 16'd1);
    step(3);
    check("R8 resumed", count_o, 36);

    // R7: count write while running, period unchanged, one-cycle pulse
    wr(2'd3, 16'd5);
    check("R7 count overwritten", count_o, 5);
    step(5);
    check("R5 reached zero", count_o, 0);
    check("R6 no irq yet", irq_o, 0);
    step(1);
    check("R6 irq with reload", irq_o, 1);
    check("R7 period kept", count_o, 100);
    step(1);
    check("R6 pulse ends", irq_o, 0);
    check("R4 after reload", count_o, 99);

    // R3: scale write loads prescaler
    wr(2'd0, 16'd0);
    wr(2'd3, 16'd10);
    wr(2'd1, 16'd2);
    wr(2'd0, 16'd1);
    step(2);
    check("R3 no step before scale+1", count_o, 10);
    step(1);
    check("R3 step at scale+1", count_o, 9);
    step(3);
    check("R3 next step", count_o, 8);

    // R5/R6: sweep of scale and period
    for (int s = 0; s < 4; s++) begin
      for (int p = 0; p < 4; p++) begin
        wr(2'd0, 16'd0);
        wr(2'd1, 16'(s));
        wr(2'd2, 16'(p));
        wr(2'd3, 16'd0);
        wr(2'd0, 16'd1);
        wait_irq(gap);
        check("R6 count at irq", count_o, p);
        for (int k = 0; k < 2; k++) begin
          wait_irq(gap);
          check("R5 interval", gap, (s + 1) * (p + 1));
          check("R6 reload value", count_o, p);
        end
      end
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule